// File: doc/BRIEF.md
# Fractional-ratio clock enable generator

This block turns a fast system clock into a stream of one-cycle enable pulses whose long-term rate equals the clock rate times a rational fraction NUM/DEN. With the default values NUM = 48 and DEN = 625, a 24 MHz clock gives an average pulse rate of exactly 1.8432 MHz, a common reference for serial baud-rate logic. Downstream logic uses the pulse as a clock enable and keeps the fast clock throughout.

In the fractional mode, a phase register counts down by NUM on every enabled clock. When a step would take it below zero, DEN is added back in the same step and a pulse is issued. The correction and the step are folded into one addition. Pulses therefore land on the fast-clock grid, each at most one clock period away from its ideal instant, and the average rate carries no error. A parameter can select a plain integer divider instead (default divide by 13, about 1.8461 MHz from 24 MHz), so that the cheaper approximation can be compared against the exact one.

The enable input gates progress. While it is low the phase is frozen and no pulse is issued, and counting resumes where it stopped.

Top module: `frac_ce_gen`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `pulse` is 0 and the phase register holds its largest legal value: DEN-1 in fractional mode and INT_DIV-1 in integer mode.
- R2: In fractional mode, counting enabled clocks from 1 after reset, `pulse` is 1 after the k-th enabled clock exactly when floor(NUM*k/DEN) exceeds floor(NUM*(k-1)/DEN). With defaults, the first pulse follows the 14th enabled clock.
- R3: In fractional mode, every run of DEN consecutive enabled clocks that starts at reset produces exactly NUM pulses (48 per 625).
- R4: In fractional mode with defaults, consecutive pulses are 13 or 14 enabled clocks apart.
- R5: `pulse` is active high and never stays high for two clocks in a row.
- R6: A clock edge with `en` low leaves the phase unchanged and gives `pulse` = 0. The pulse pattern then continues as if the disabled clocks had not occurred.
- R7: If `en` is low on the clock where the phase would wrap, no pulse is issued there, and the pulse follows the next enabled clock instead.
- R8: In integer mode, `pulse` is 1 after every INT_DIV-th enabled clock counted from reset (default 13), and is 0 otherwise.
- R9: In integer mode, clocks with `en` low neither advance the count nor produce a pulse.
- R10: A reset that falls on the clock where a wrap is due takes priority. No pulse is issued, and the sequence restarts as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the phase |
| pulse | output | 1 | Registered one-cycle rate pulse, active high |

## Verification
Two events can fall on the same clock as a due wrap: the enable being dropped, and a synchronous reset. The bench predicts from floor(NUM*k/DEN) which enabled clock will wrap next. It lowers `en` on exactly that clock for several cycles and expects silence, followed by a pulse on the next enabled clock. In a separate run it raises `rst` on a wrap clock and expects no pulse, followed by a first pulse at the 14th enabled clock after reset. Throughout, every clock of both the fractional and the integer instance is judged against the arithmetic expectation, and pulse gaps and per-window pulse counts are tallied as well.

// File: rtl/frac_ce_pkg.sv
package frac_ce_pkg;

  typedef enum logic {
    DIV_FRACTIONAL = 1'b0,
    DIV_INTEGER    = 1'b1
  } div_mode_e;

  // Magnitude bits for values up to limit-1, plus one sign bit for wrap detection.
  function automatic int unsigned phase_width(input int unsigned limit);
    return $clog2(limit) + 1;
  endfunction

  // Phase period in clocks for the selected mode.
  function automatic int unsigned phase_limit(input div_mode_e mode,
                                              input int unsigned den,
                                              input int unsigned idiv);
    return (mode == DIV_FRACTIONAL) ? den : idiv;
  endfunction

endpackage

// File: rtl/frac_ce_phase.sv
module frac_ce_phase #(
  parameter int unsigned NUM = 48,
  parameter int unsigned DEN = 625,
  parameter int unsigned W   = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] acc_q,
  output logic         wrap
);
  localparam logic [W-1:0] STEP_DN = W'(NUM);
  localparam logic [W-1:0] NEG_DN  = ~STEP_DN + W'(1);
  localparam logic [W-1:0] STEP_UP = W'(DEN - NUM);
  localparam logic [W-1:0] RESET_V = W'(DEN - 1);

  logic [W-1:0] trial;
  logic [W-1:0] addend;
  logic [W-1:0] acc_d;

  // Trial step; its sign bit marks a wrap, because acc_q < DEN < 2**(W-1).
  assign trial  = acc_q - STEP_DN;
  assign wrap   = trial[W-1];
  // Correction and step are folded into one addend.
  assign addend = wrap ? STEP_UP : NEG_DN;
  assign acc_d  = acc_q + addend;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= RESET_V;
    else if (en) acc_q <= acc_d;
  end
endmodule

// File: rtl/frac_ce_intdiv.sv
module frac_ce_intdiv #(
  parameter int unsigned DIV = 13,
  parameter int unsigned W   = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  localparam logic [W-1:0] RELOAD = W'(DIV - 1);

  assign wrap = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= RELOAD;
    else if (en)   cnt_q <= wrap ? RELOAD : cnt_q - W'(1);
  end
endmodule

// File: rtl/frac_ce_pulse_reg.sv
module frac_ce_pulse_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wrap,
  output logic pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= en & wrap;
  end
endmodule

// File: rtl/frac_ce_gen.sv
module frac_ce_gen #(
  parameter frac_ce_pkg::div_mode_e MODE = frac_ce_pkg::DIV_FRACTIONAL,
  parameter int unsigned NUM     = 48,
  parameter int unsigned DEN     = 625,
  parameter int unsigned INT_DIV = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse
);
  localparam int unsigned LIMIT = frac_ce_pkg::phase_limit(MODE, DEN, INT_DIV);
  localparam int unsigned W     = frac_ce_pkg::phase_width(LIMIT);

  // Internal events brought out for the bound checker.
  logic [W-1:0] acc_w;
  logic         wrap_w;

  generate
    if (MODE == frac_ce_pkg::DIV_FRACTIONAL) begin : g_frac
      frac_ce_phase #(.NUM(NUM), .DEN(DEN), .W(W)) phase_i (
        .clk(clk), .rst(rst), .en(en), .acc_q(acc_w), .wrap(wrap_w)
      );
    end else begin : g_int
      frac_ce_intdiv #(.DIV(INT_DIV), .W(W)) div_i (
        .clk(clk), .rst(rst), .en(en), .cnt_q(acc_w), .wrap(wrap_w)
      );
    end
  endgenerate

  frac_ce_pulse_reg out_i (
    .clk(clk), .rst(rst), .en(en), .wrap(wrap_w), .pulse_q(pulse)
  );
endmodule

// File: rtl/frac_ce_gen_chk.sv
module frac_ce_gen_chk #(
  parameter int unsigned LIMIT = 625,
  parameter int unsigned W     = 11
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         wrap,
  input logic [W-1:0] acc,
  input logic         pulse
);
  localparam logic [W-1:0] TOP_V = W'(LIMIT - 1);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!pulse && acc == TOP_V));

  p_acc_range_r2: assert property (@(posedge clk) disable iff (rst)
    acc <= TOP_V);

  p_wrap_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (en && wrap) |=> pulse);

  p_pulse_cause_r2: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(en && wrap));

  p_single_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  p_hold_phase_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pulse);
endmodule

bind frac_ce_gen frac_ce_gen_chk #(.LIMIT(LIMIT), .W(W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .wrap(wrap_w), .acc(acc_w), .pulse(pulse)
);

// File: tb/frac_ce_gen_tb_top.sv
module frac_ce_gen_tb_top;
  localparam longint B_NUM = 48;
  localparam longint B_DEN = 625;
  localparam longint B_DIV = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic pulse_f, pulse_i;

  int     total = 0;
  int     bad   = 0;
  longint k     = 0;
  longint last_k = 0;
  int     win_cnt = 0;
  logic   prev_f = 1'b0;
  logic   prev_i = 1'b0;

  always #5 clk = ~clk;

  frac_ce_gen #(.MODE(frac_ce_pkg::DIV_FRACTIONAL), .NUM(48), .DEN(625), .INT_DIV(13))
    dut_i (.clk(clk), .rst(rst), .en(en), .pulse(pulse_f));

  frac_ce_gen #(.MODE(frac_ce_pkg::DIV_INTEGER), .NUM(48), .DEN(625), .INT_DIV(13))
    dut_div_i (.clk(clk), .rst(rst), .en(en), .pulse(pulse_i));

  function automatic logic frac_fires(input longint n);
    return ((n * B_NUM) / B_DEN) != (((n - 1) * B_NUM) / B_DEN);
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b (enabled count %0d)", req, act, exp, k);
    end
  endtask

  task automatic tick(input logic e, input logic r, input string rf, input string ri);
    logic ef, ei;
    en  = e;
    rst = r;
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      k = 0; last_k = 0; win_cnt = 0; ef = 1'b0; ei = 1'b0;
    end else if (e) begin
      k++;
      ef = frac_fires(k);
      ei = (k % B_DIV) == 0;
    end else begin
      ef = 1'b0; ei = 1'b0;
    end
    chk(pulse_f, ef, rf);
    chk(pulse_i, ei, ri);
    if (prev_f) chk(pulse_f, 1'b0, "R5");
    if (prev_i) chk(pulse_i, 1'b0, "R5");
    if (!r && e && pulse_f) begin
      win_cnt++;
      if (last_k != 0) chk(((k - last_k) == 13) || ((k - last_k) == 14), 1'b1, "R4");
      last_k = k;
    end
    if (!r && e && (k % B_DEN) == 0 && k != 0) begin
      chk(win_cnt == int'(B_NUM), 1'b1, "R3");
      win_cnt = 0;
    end
    prev_f = pulse_f;
    prev_i = pulse_i;
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, "R1", "R1");
    tick(1'b0, 1'b0, "R6", "R9");
    // R1/R2/R8: first pulses and long run with enable held high
    for (int i = 0; i < 13; i++) tick(1'b1, 1'b0, "R1", "R8");
    tick(1'b1, 1'b0, "R1 first pulse", "R8");
    for (int i = 0; i < 2500; i++) tick(1'b1, 1'b0, "R2", "R8");
    // R6/R9: gated enable patterns
    for (int i = 0; i < 1500; i++) tick((i % 5) != 2, 1'b0, "R6", "R9");
    for (int i = 0; i < 600; i++) tick((i % 7) < 3, 1'b0, "R6", "R9");
    // R7: enable dropped exactly on a due wrap
    for (int rep = 0; rep < 4; rep++) begin
      while (!frac_fires(k + 1)) tick(1'b1, 1'b0, "R2", "R8");
      for (int j = 0; j < 3 + rep; j++) tick(1'b0, 1'b0, "R7", "R9");
      tick(1'b1, 1'b0, "R7", "R8");
      chk(pulse_f, 1'b1, "R7 delayed pulse");
    end
    // R10: reset on a due wrap, then restart
    while (!frac_fires(k + 1)) tick(1'b1, 1'b0, "R2", "R8");
    tick(1'b1, 1'b1, "R10", "R10");
    for (int i = 0; i < 14; i++) tick(1'b1, 1'b0, "R10", "R8");
    chk(pulse_f, 1'b1, "R10 restart pulse");
    for (int i = 0; i < 1300; i++) tick(1'b1, 1'b0, "R3", "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule